// File: doc/BRIEF.md
# Two-Phase Cross-Domain Link Buffer

This block carries flits from a sender in one clock domain to a receiver in an unrelated clock domain. It uses non-return-to-zero signalling: each accepted flit flips a request line, and each flit the receiver consumes flips an acknowledge line. The meaning lies in the transitions, not in the levels. The flits sit in a seven-slot circular store on the receiving side. Each side keeps its own write and read Johnson-counter pointers. Every slot has its own free flag, taken from the matching bits of the two pointers: a slot is free when the bits are equal and occupied when they differ.

The only signals that cross between the domains are the pointer vectors, one bit per slot. Each passes through a two-flop synchronizer. The sender therefore streams flits without waiting for each acknowledge, and stops only when the slot it would write next is still occupied. Seven slots cover the whole round trip: one write cycle, two cycles to synchronize the request, one read cycle and two cycles to synchronize the acknowledge. With equal clocks this sustains one flit per cycle. The behaviour of both ends is built from clocked logic.

Top module: `jl_link`

## Requirements
- R1: While either reset is low and right after release, ready_o is 1, valid_o is 0, and req_o and ack_o are both 0.
- R2: Every flit accepted on the send side (push_i and ready_o high at a clk_tx_i edge) leaves data_o exactly once. Flits leave in the order they were accepted. Nothing is lost or duplicated, at any ratio of the two clocks.
- R3: req_o inverts at each tx edge that accepts a flit and holds its value at every other tx edge.
- R4: ack_o inverts at each rx edge where pop_i and valid_o are both high and holds its value at every other rx edge.
- R5: After seven accepted flits with none consumed, ready_o is 0. A push offered while ready_o is 0 is dropped: it never reaches data_o, and no stored flit is overwritten.
- R6: With both clocks at the same frequency and pop_i held high, ready_o never drops during a sustained stream. The sender places one flit per cycle.
- R7: A flit accepted at a tx edge makes valid_o high after the second rx edge that follows it. valid_o is still low after the first such edge.
- R8: Once valid_o is high, valid_o and data_o keep their values at every rx edge until the flit is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx_i | input | 1 | Sender clock |
| rst_tx_ni | input | 1 | Sender-side asynchronous reset, active low |
| push_i | input | 1 | Offer data_i this cycle |
| data_i | input | WIDTH | Flit offered by the sender |
| ready_o | output | 1 | Next write slot is free; a push is accepted |
| req_o | output | 1 | Two-phase request, flips once per accepted flit |
| clk_rx_i | input | 1 | Receiver clock |
| rst_rx_ni | input | 1 | Receiver-side asynchronous reset, active low |
| pop_i | input | 1 | Consume the presented flit |
| valid_o | output | 1 | data_o holds an unread flit |
| data_o | output | WIDTH | Oldest unread flit |
| ack_o | output | 1 | Two-phase acknowledge, flips once per consumed flit |

## Verification
The two toggles, req_o and ack_o, change at the same edge that accepts or consumes a flit. A flit becomes visible on valid_o only after the second rx edge that follows its write. A freed slot shows up on ready_o only after the second tx edge that follows the pop. The bench changes inputs on falling edges and samples ready_o, valid_o and data_o there, or 1 ns after a rising edge. This keeps every sample between the edges that could move the value. The latency check samples valid_o after the first and after the second rx edge that follow a single write. The phase offset between the two clocks keeps those edges apart in time.

// File: rtl/jl_pkg.sv
`timescale 1ns/1ps
package jl_pkg;

  // Johnson step on the low n bits of j
  function automatic logic [31:0] jc_next(logic [31:0] j, int unsigned n);
    logic [31:0] mask;
    mask = (32'h1 << n) - 32'h1;
    return ((j << 1) | {31'b0, ~j[n-1]}) & mask;
  endfunction

  // slot addressed by a Johnson state: count of bits differing from the MSB
  function automatic int unsigned jc_index(logic [31:0] j, int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < 32; i++)
      if (i < n) c += int'(j[i] ^ j[n-1]);
    return c;
  endfunction

endpackage

// File: rtl/jl_sync.sv
`timescale 1ns/1ps
module jl_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/jl_store.sv
`timescale 1ns/1ps
module jl_store #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // written by the sender clock, held until the slot is freed
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/jl_tx.sv
`timescale 1ns/1ps
module jl_tx
  import jl_pkg::*;
#(
  parameter int unsigned DEPTH = 7,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DEPTH-1:0] rd_ptr_i,
  output logic             ready_o,
  output logic             req_o,
  output logic             wr_en_o,
  output logic [IW-1:0]    wr_idx_o,
  output logic [DEPTH-1:0] wr_ptr_o
);
  logic [DEPTH-1:0] rd_s;
  logic [DEPTH-1:0] wr_q, wr_nx;
  logic [31:0]      nx32;
  logic             req_q, fire;

  jl_sync #(.W(DEPTH)) u_rd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rd_ptr_i),
    .q_o   (rd_s)
  );

  assign nx32     = jc_next(32'(wr_q), DEPTH);
  assign wr_nx    = nx32[DEPTH-1:0];
  assign wr_idx_o = IW'(jc_index(32'(wr_q), DEPTH));
  assign ready_o  = (wr_q[wr_idx_o] == rd_s[wr_idx_o]);
  assign fire     = push_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      req_q <= 1'b0;
    end else if (fire) begin
      wr_q  <= wr_nx;
      req_q <= ~req_q;
    end
  end

  assign wr_en_o  = fire;
  assign wr_ptr_o = wr_q;
  assign req_o    = req_q;
endmodule

// File: rtl/jl_rx.sv
`timescale 1ns/1ps
module jl_rx
  import jl_pkg::*;
#(
  parameter int unsigned DEPTH = 7,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic [DEPTH-1:0] wr_ptr_i,
  output logic             valid_o,
  output logic             ack_o,
  output logic [IW-1:0]    rd_idx_o,
  output logic [DEPTH-1:0] rd_ptr_o
);
  logic [DEPTH-1:0] wr_s;
  logic [DEPTH-1:0] rd_q, rd_nx;
  logic [31:0]      nx32;
  logic             ack_q, fire;

  jl_sync #(.W(DEPTH)) u_wr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_ptr_i),
    .q_o   (wr_s)
  );

  assign nx32     = jc_next(32'(rd_q), DEPTH);
  assign rd_nx    = nx32[DEPTH-1:0];
  assign rd_idx_o = IW'(jc_index(32'(rd_q), DEPTH));
  assign valid_o  = (wr_s[rd_idx_o] != rd_q[rd_idx_o]);
  assign fire     = pop_i & valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      ack_q <= 1'b0;
    end else if (fire) begin
      rd_q  <= rd_nx;
      ack_q <= ~ack_q;
    end
  end

  assign rd_ptr_o = rd_q;
  assign ack_o    = ack_q;
endmodule

// File: rtl/jl_link.sv
`timescale 1ns/1ps
module jl_link #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk_tx_i,
  input  logic             rst_tx_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ready_o,
  output logic             req_o,
  input  logic             clk_rx_i,
  input  logic             rst_rx_ni,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic             ack_o
);
  logic [DEPTH-1:0] tx_wr_ptr, rx_rd_ptr;
  logic [IW-1:0]    tx_wr_idx, rx_rd_idx;
  logic             tx_wr_en;

  jl_tx #(.DEPTH(DEPTH)) u_tx (
    .clk_i   (clk_tx_i),
    .rst_ni  (rst_tx_ni),
    .push_i  (push_i),
    .rd_ptr_i(rx_rd_ptr),
    .ready_o (ready_o),
    .req_o   (req_o),
    .wr_en_o (tx_wr_en),
    .wr_idx_o(tx_wr_idx),
    .wr_ptr_o(tx_wr_ptr)
  );

  jl_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i  (clk_tx_i),
    .we_i   (tx_wr_en),
    .waddr_i(tx_wr_idx),
    .wdata_i(data_i),
    .raddr_i(rx_rd_idx),
    .rdata_o(data_o)
  );

  jl_rx #(.DEPTH(DEPTH)) u_rx (
    .clk_i   (clk_rx_i),
    .rst_ni  (rst_rx_ni),
    .pop_i   (pop_i),
    .wr_ptr_i(tx_wr_ptr),
    .valid_o (valid_o),
    .ack_o   (ack_o),
    .rd_idx_o(rx_rd_idx),
    .rd_ptr_o(rx_rd_ptr)
  );
endmodule

// File: rtl/jl_link_chk.sv
`timescale 1ns/1ps
module jl_link_chk #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input logic             clk_tx_i,
  input logic             rst_tx_ni,
  input logic             push_i,
  input logic             ready_o,
  input logic             req_o,
  input logic             clk_rx_i,
  input logic             rst_rx_ni,
  input logic             pop_i,
  input logic             valid_o,
  input logic [WIDTH-1:0] data_o,
  input logic             ack_o,
  input logic [DEPTH-1:0] tx_wr_ptr,
  input logic [DEPTH-1:0] rx_rd_ptr,
  input logic [IW-1:0]    tx_wr_idx
);
  // R5
  no_overwrite_chk: assert property (@(posedge clk_tx_i) disable iff (!rst_tx_ni || !rst_rx_ni)
    (push_i && ready_o) |-> (tx_wr_ptr[tx_wr_idx] == rx_rd_ptr[tx_wr_idx]));

  // R3
  req_flip_chk: assert property (@(posedge clk_tx_i) disable iff (!rst_tx_ni)
    (push_i && ready_o) |=> (req_o != $past(req_o)));

  // R3
  req_hold_chk: assert property (@(posedge clk_tx_i) disable iff (!rst_tx_ni)
    !(push_i && ready_o) |=> $stable(req_o));

  // R4
  ack_flip_chk: assert property (@(posedge clk_rx_i) disable iff (!rst_rx_ni)
    (pop_i && valid_o) |=> (ack_o != $past(ack_o)));

  // R4
  ack_hold_chk: assert property (@(posedge clk_rx_i) disable iff (!rst_rx_ni)
    !(pop_i && valid_o) |=> $stable(ack_o));

  // R8
  valid_hold_chk: assert property (@(posedge clk_rx_i) disable iff (!rst_rx_ni || !rst_tx_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));
endmodule

bind jl_link jl_link_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk_tx_i (clk_tx_i),
  .rst_tx_ni(rst_tx_ni),
  .push_i   (push_i),
  .ready_o  (ready_o),
  .req_o    (req_o),
  .clk_rx_i (clk_rx_i),
  .rst_rx_ni(rst_rx_ni),
  .pop_i    (pop_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .ack_o    (ack_o),
  .tx_wr_ptr(tx_wr_ptr),
  .rx_rd_ptr(rx_rd_ptr),
  .tx_wr_idx(tx_wr_idx)
);

// File: tb/jl_link_test.sv
`timescale 1ns/1ps
module jl_link_test;
  localparam int W = 16;

  logic         clk_tx = 1'b0, clk_rx = 1'b0;
  logic         rst_tx_n = 1'b0, rst_rx_n = 1'b0;
  logic         push_i = 1'b0, pop_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         ready_o, req_o, valid_o, ack_o;
  logic [W-1:0] data_o;

  int vec = 0, errs = 0;
  int rx_half = 10;
  int pop_mode = 0;
  bit live = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] sb[$];
  logic [W-1:0] next_v = 16'h1000;
  int acc_total = 0, pops = 0, req_tog = 0, ack_tog = 0;
  logic req_prev = 1'b0, ack_prev = 1'b0;
  bit held = 1'b0, alt = 1'b0;
  logic [W-1:0] held_d;

  jl_link uut (
    .clk_tx_i (clk_tx),
    .rst_tx_ni(rst_tx_n),
    .push_i   (push_i),
    .data_i   (data_i),
    .ready_o  (ready_o),
    .req_o    (req_o),
    .clk_rx_i (clk_rx),
    .rst_rx_ni(rst_rx_n),
    .pop_i    (pop_i),
    .valid_o  (valid_o),
    .data_o   (data_o),
    .ack_o    (ack_o)
  );

  always #10 clk_tx = ~clk_tx;
  initial begin
    #5;
    forever #(rx_half) clk_rx = ~clk_rx;
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
    end
  endtask

  // R3: req toggle counter
  always @(negedge clk_tx) if (live) begin
    if (req_o != req_prev) req_tog++;
    req_prev = req_o;
  end

  // scoreboard monitor on the receive side (R2, R4, R8)
  always @(negedge clk_rx) if (live) begin
    logic p;
    if (ack_o != ack_prev) ack_tog++;
    ack_prev = ack_o;
    if (held) check(valid_o && data_o == held_d, "R8", {15'b0, valid_o, data_o}, {16'h1, held_d});
    alt = ~alt;
    p = (pop_mode == 1) || (pop_mode == 2 && alt);
    pop_i = p;
    if (p && valid_o) begin
      if (sb.size() == 0) check(1'b0, "R2", {16'b0, data_o}, 32'hFFFF_FFFF);
      else begin
        logic [W-1:0] e;
        e = sb.pop_front();
        check(data_o == e, "R2", {16'b0, data_o}, {16'b0, e});
      end
      pops++;
    end
    held = valid_o && !p;
    held_d = data_o;
  end

  task automatic push_n(int n, output int acc, output int refused);
    acc = 0;
    refused = 0;
    for (int i = 0; i < n; i++) begin
      bit r;
      @(negedge clk_tx);
      push_i = 1'b1;
      data_i = next_v;
      r = ready_o;
      @(posedge clk_tx);
      if (r) begin
        sb.push_back(data_i);
        next_v++;
        acc++;
      end else refused++;
    end
    @(negedge clk_tx);
    push_i = 1'b0;
    acc_total += acc;
  endtask

  task automatic drain(string req);
    pop_mode = 1;
    for (int i = 0; i < 5000 && sb.size() != 0; i++) @(negedge clk_tx);
    repeat (20) @(negedge clk_tx);
    check(sb.size() == 0, req, sb.size(), 0);
    @(posedge clk_rx); #1;
    check(valid_o == 1'b0, req, {31'b0, valid_o}, 0);
  endtask

  initial begin
    #(20 * 190000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int a, r;
    repeat (3) @(negedge clk_tx);
    // R1: values held in reset
    check(ready_o == 1'b1, "R1", {31'b0, ready_o}, 1);
    check(valid_o == 1'b0, "R1", {31'b0, valid_o}, 0);
    rst_tx_n = 1'b1;
    rst_rx_n = 1'b1;
    live = 1'b1;
    @(negedge clk_tx);
    check(req_o == 1'b0 && ack_o == 1'b0, "R1", {30'b0, req_o, ack_o}, 0);
    check(ready_o == 1'b1 && valid_o == 1'b0, "R1", {30'b0, ready_o, valid_o}, 32'h2);

    // R7: one flit, no pop; visible after the second rx edge
    pop_mode = 0;
    @(negedge clk_tx);
    push_i = 1'b1;
    data_i = next_v;
    @(posedge clk_tx);
    sb.push_back(data_i);
    next_v++;
    acc_total++;
    #1 push_i = 1'b0;
    @(posedge clk_rx); #1;
    check(valid_o == 1'b0, "R7", {31'b0, valid_o}, 0);
    @(posedge clk_rx); #1;
    check(valid_o == 1'b1 && data_o == sb[0], "R7", {15'b0, valid_o, data_o}, {16'h1, sb[0]});
    drain("R2");

    // R5: fill without popping; extra pushes refused
    pop_mode = 0;
    push_n(10, a, r);
    check(a == 7, "R5", a, 7);
    check(r == 3, "R5", r, 3);
    check(ready_o == 1'b0, "R5", {31'b0, ready_o}, 0);
    repeat (10) @(negedge clk_tx);
    check(valid_o == 1'b1, "R5", {31'b0, valid_o}, 1);
    drain("R5");

    // R6: equal clocks, sustained stream
    pop_mode = 1;
    push_n(40, a, r);
    check(r == 0, "R6", r, 0);
    check(a == 40, "R6", a, 40);
    drain("R6");

    // R2: slow receiver popping every other cycle
    rx_half = 30;
    pop_mode = 2;
    push_n(40, a, r);
    drain("R2");

    // R2: fast receiver
    rx_half = 4;
    pop_mode = 1;
    push_n(40, a, r);
    drain("R2");

    repeat (5) @(negedge clk_tx);
    check(pops == acc_total, "R2", pops, acc_total);
    check(req_tog == acc_total, "R3", req_tog, acc_total);
    check(ack_tog == pops, "R4", ack_tog, pops);
    finish_run();
  end
endmodule